// File: doc/BRIEF.md
# Filtered Latch-Off Fault Detector

This block decides when an off-line converter controller must shut down for good. It watches two comparator flags. The first comes from an external protection pin that senses output overvoltage or overtemperature. The second comes from a supply-rail overvoltage comparator. Once either fault is confirmed, the block raises a latched-off state and cuts every gate pulse. That state holds until the supply collapses and a supply reset arrives.

The external flag goes through three qualification stages before it counts:

- **Width filter:** a trip shorter than a minimum width is discarded.
- **Blanking:** the flag is ignored for a fixed window after each gate turn-off, so the leakage-inductance ringing that follows cannot cause a trip.
- **Consecutive-cycle count:** the latch fires only after qualified trips appear in several switching periods in a row.

The supply-overvoltage flag takes a separate, simpler path. It must stay asserted without a break for a long persistence time. Every time window is given in system clock cycles. The defaults are 600 ns of width, 1 µs of blanking, four periods and 20 ms of persistence, all at a 100 MHz clock.

Top module: `latchoff_guard`

## Requirements
- R1: An external trip counts as qualified only once `ext_trip` has been sampled high on FILT_CYC consecutive clock edges outside blanking. A shorter run is discarded and its partial count returns to zero.
- R2: The clock edge that first samples `gate_in` low after it was high starts blanking. `ext_trip` is ignored on that edge and on the following BLANK_CYC edges.
- R3: A switching period is the span between two `cycle_start` pulses. A one-cycle high pulse on `cycle_start` closes the current period. The closed period counts as qualified if it held at least one qualified trip.
- R4: `latched_off` rises on the edge after the `cycle_start` that closes the CONFIRM_CNT-th qualified period in a row. Any period closed with no qualified trip resets the run to zero.
- R5: `latched_off` rises on the edge after `vsup_ovp` has been sampled high on OVP_CYC consecutive edges. Sampling `vsup_ovp` low restarts the persistence count from zero.
- R6: Once high, `latched_off` stays high whatever `ext_trip`, `vsup_ovp`, `gate_in` and `cycle_start` do, until `supply_rst_n` goes low.
- R7: `gate_out` follows `gate_in` combinationally while `latched_off` is low. It is forced low in the same cycle that `latched_off` is high.
- R8: Driving `supply_rst_n` low asynchronously clears `latched_off` and all qualification state: width count, blanking, period run and persistence count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| supply_rst_n | input | 1 | Active-low asynchronous supply reset, the only release of the latch |
| ext_trip | input | 1 | External protection comparator flag |
| vsup_ovp | input | 1 | Supply-rail overvoltage comparator flag |
| gate_in | input | 1 | Requested gate drive from the modulator |
| cycle_start | input | 1 | One-cycle pulse marking the start of each switching period |
| latched_off | output | 1 | Permanent shutdown state |
| gate_out | output | 1 | Gate drive after the shutdown inhibit |

## Verification
The embedded properties are checked on every cycle. They cover the following:

- A qualified trip always comes from a sampled high flag outside blanking.
- A blanked edge always clears the width count.
- An empty period always resets the run.
- A low supply flag always restarts persistence.
- The latch never drops without a reset.
- Every rise of the latch traces back to a fire from one of the two paths.

Three behaviours can only be shown by the bench's scenarios, because each depends on how stimulus falls across many cycles:

- The exact width boundary of the filter.
- Pulses hidden wholly inside the blanking window being rejected.
- The exact count of consecutive periods needed, including a run broken one period short of it.

The same holds for the one-edge-short persistence case and for release only by reset.

// File: rtl/latchoff_pkg.sv
package latchoff_pkg;
   // counter width able to hold values 0..n
   function automatic int cnt_w(input int n);
      int w;
      w = $clog2(n + 1);
      return (w < 1) ? 1 : w;
   endfunction
endpackage

// File: rtl/lo_blank_window.sv
module lo_blank_window #(
   parameter int BLANK_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_in,
   output logic blanked
);
   import latchoff_pkg::*;
   localparam int BW = cnt_w(BLANK_CYC);
   localparam logic [BW-1:0] BLANK_V = BW'(BLANK_CYC);

   logic          gate_d;
   logic [BW-1:0] left_q;
   logic          fall;

   assign fall    = gate_d & ~gate_in;
   assign blanked = fall | (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_d <= 1'b0;
         left_q <= '0;
      end else begin
         gate_d <= gate_in;
         if (fall)
            left_q <= BLANK_V;
         else if (left_q != '0)
            left_q <= left_q - 1'b1;
      end
   end

   // R2: counting down never skips a step unless a new turn-off reloads
   p_blank_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && left_q != '0) |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/lo_width_filter.sv
module lo_width_filter #(
   parameter int FILT_CYC = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_in,
   input  logic blank_in,
   output logic qual
);
   import latchoff_pkg::*;
   localparam int FW = cnt_w(FILT_CYC);
   localparam logic [FW-1:0] FILT_V = FW'(FILT_CYC);

   logic [FW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (trip_in && !blank_in)
         run_q <= (run_q == FILT_V) ? run_q : run_q + 1'b1;
      else
         run_q <= '0;
   end

   assign qual = (run_q == FILT_V);

   // R1: a qualified level implies a valid unblanked trip sample just before
   p_qual_needs_trip_r1: assert property (@(posedge clk) disable iff (!rst_n)
      qual |-> $past(trip_in && !blank_in));
   // R2: a blanked sample always discards the partial run
   p_blank_clears_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      blank_in |=> (run_q == '0));
endmodule

// File: rtl/lo_cycle_confirm.sv
module lo_cycle_confirm #(
   parameter int CONFIRM_CNT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic cycle_start,
   output logic fire
);
   import latchoff_pkg::*;

   logic seen_q;
   logic seen_any;

   assign seen_any = seen_q | evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= 1'b0;
      else if (cycle_start)
         seen_q <= 1'b0;
      else if (evt)
         seen_q <= 1'b1;
   end

   generate
      if (CONFIRM_CNT == 1) begin : g_single
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hit_q <= 1'b0;
            else
               hit_q <= cycle_start & seen_any;
         end
         assign fire = hit_q;
      end else begin : g_multi
         localparam int SW = cnt_w(CONFIRM_CNT);
         localparam logic [SW-1:0] CONF_V = SW'(CONFIRM_CNT);
         logic [SW-1:0] streak_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               streak_q <= '0;
            else if (cycle_start) begin
               if (seen_any)
                  streak_q <= (streak_q == CONF_V) ? streak_q : streak_q + 1'b1;
               else
                  streak_q <= '0;
            end
         end
         assign fire = (streak_q == CONF_V);

         // R4: an empty period breaks the run
         p_streak_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cycle_start && !seen_any) |=> (streak_q == '0));
      end
   endgenerate
endmodule

// File: rtl/lo_persist_timer.sv
module lo_persist_timer #(
   parameter int OVP_CYC = 2_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_in,
   output logic done
);
   import latchoff_pkg::*;
   localparam int PW = cnt_w(OVP_CYC);
   localparam logic [PW-1:0] OVP_V = PW'(OVP_CYC);

   logic [PW-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age_q <= '0;
      else if (!flag_in)
         age_q <= '0;
      else if (age_q != OVP_V)
         age_q <= age_q + 1'b1;
   end

   assign done = (age_q == OVP_V);

   // R5: a low flag sample always restarts persistence
   p_ovp_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_in |=> (age_q == '0));
endmodule

// File: rtl/latchoff_guard.sv
module latchoff_guard #(
   parameter int FILT_CYC    = 60,
   parameter int BLANK_CYC   = 100,
   parameter int CONFIRM_CNT = 4,
   parameter int OVP_CYC     = 2_000_000
) (
   input  logic clk,
   input  logic supply_rst_n,
   input  logic ext_trip,
   input  logic vsup_ovp,
   input  logic gate_in,
   input  logic cycle_start,
   output logic latched_off,
   output logic gate_out
);
   generate
      if (FILT_CYC < 1)    begin : g_bad_filt  $error("FILT_CYC must be at least 1");    end
      if (BLANK_CYC < 0)   begin : g_bad_blank $error("BLANK_CYC must not be negative");  end
      if (CONFIRM_CNT < 1) begin : g_bad_conf  $error("CONFIRM_CNT must be at least 1"); end
      if (OVP_CYC < 1)     begin : g_bad_ovp   $error("OVP_CYC must be at least 1");     end
   endgenerate

   logic blanked;
   logic qual;
   logic ext_fire;
   logic ovp_fire;
   logic lat_q;

   lo_blank_window #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk(clk), .rst_n(supply_rst_n), .gate_in(gate_in), .blanked(blanked));

   lo_width_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(supply_rst_n), .trip_in(ext_trip),
      .blank_in(blanked), .qual(qual));

   lo_cycle_confirm #(.CONFIRM_CNT(CONFIRM_CNT)) u_conf (
      .clk(clk), .rst_n(supply_rst_n), .evt(qual),
      .cycle_start(cycle_start), .fire(ext_fire));

   lo_persist_timer #(.OVP_CYC(OVP_CYC)) u_ovp (
      .clk(clk), .rst_n(supply_rst_n), .flag_in(vsup_ovp), .done(ovp_fire));

   always_ff @(posedge clk or negedge supply_rst_n) begin
      if (!supply_rst_n)
         lat_q <= 1'b0;
      else if (ext_fire || ovp_fire)
         lat_q <= 1'b1;
   end

   assign latched_off = lat_q;
   assign gate_out    = gate_in & ~lat_q;

   // R6: the latch never releases without a supply reset
   p_latch_hold_r6: assert property (@(posedge clk) disable iff (!supply_rst_n)
      latched_off |=> latched_off);
   // R6: every rise has a confirmed cause from one of the two paths
   p_latch_cause_r6: assert property (@(posedge clk) disable iff (!supply_rst_n)
      $rose(latched_off) |-> $past(ext_fire || ovp_fire));
   // R7: no gate pulse leaves while latched
   p_gate_inhibit_r7: assert property (@(posedge clk) disable iff (!supply_rst_n)
      latched_off |-> !gate_out);
endmodule

// File: tb/test_latchoff_guard.sv
module test_latchoff_guard;
   localparam int FILT  = 6;
   localparam int BLANK = 10;
   localparam int CONF  = 4;
   localparam int OVPC  = 200;
   localparam int PER   = 64;

   logic clk = 1'b0;
   logic supply_rst_n = 1'b0;
   logic ext_trip = 1'b0, vsup_ovp = 1'b0, gate_in = 1'b0, cycle_start = 1'b0;
   logic latched_off, gate_out;

   int checks = 0;
   int fails  = 0;
   int streak = 0;
   bit prev_q = 1'b0;
   bit exp_lat = 1'b0;

   always #5 clk = ~clk;

   latchoff_guard #(.FILT_CYC(FILT), .BLANK_CYC(BLANK), .CONFIRM_CNT(CONF),
                    .OVP_CYC(OVPC)) i_latchoff_guard (
      .clk(clk), .supply_rst_n(supply_rst_n), .ext_trip(ext_trip),
      .vsup_ovp(vsup_ovp), .gate_in(gate_in), .cycle_start(cycle_start),
      .latched_off(latched_off), .gate_out(gate_out));

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic bit period_qual(input int w, input bit inblank, input bit pulse);
      return pulse && !inblank && (w >= FILT);
   endfunction

   task automatic do_reset();
      supply_rst_n = 1'b0;
      ext_trip = 0; vsup_ovp = 0; gate_in = 0; cycle_start = 0;
      #3;
      check("R8 async clear", latched_off, 1'b0);
      tick(); tick();
      supply_rst_n = 1'b1;
      streak = 0; prev_q = 0; exp_lat = 0;
   endtask

   // one switching period: gate high idx 0..9, blanking idx 10..20
   task automatic run_period(input int w, input bit inblank, input bit pulse, input string req);
      int st;
      st = inblank ? 11 : 30;
      // bench model of the period closed by this period's cycle_start (R3, R4)
      streak = prev_q ? ((streak < CONF) ? streak + 1 : streak) : 0;
      if (streak >= CONF) exp_lat = 1'b1;
      prev_q = period_qual(w, inblank, pulse);
      for (int i = 0; i < PER; i++) begin
         cycle_start = (i == 0);
         gate_in     = (i < 10);
         ext_trip    = pulse && (i >= st) && (i < st + w);
         if (i == 3) begin
            #2;
            check(req, latched_off, exp_lat);
            check("R7 gate pass/inhibit", gate_out, !exp_lat);
         end
         tick();
      end
      ext_trip = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      #2;
      check("R8 reset state", latched_off, 1'b0);
      tick(); tick();
      supply_rst_n = 1'b1;
      tick();

      // R1 width boundary: FILT-1 never qualifies, so four periods do not latch
      for (int k = 0; k < 5; k++) run_period(FILT - 1, 0, 1, "R1 short pulses ignored");
      // R2 wide pulses wholly inside blanking are ignored
      for (int k = 0; k < 5; k++) run_period(8, 1, 1, "R2 blanked pulses ignored");
      // R4 run of three broken by an empty period
      for (int k = 0; k < 3; k++) run_period(FILT, 0, 1, "R4 run building");
      run_period(0, 0, 0, "R4 break period");
      for (int k = 0; k < 3; k++) run_period(FILT, 0, 1, "R4 run after break");
      run_period(FILT, 0, 1, "R4 fourth qualified period");
      run_period(0, 0, 0, "R4 latch after four");
      check("R4 latched", latched_off, 1'b1);
      // R6 stays latched with quiet and noisy inputs
      run_period(12, 0, 1, "R6 hold while latched");
      run_period(0, 0, 0, "R6 hold while latched");
      do_reset();

      // constrained random periods
      for (int k = 0; k < 60; k++) begin
         bit ib, pl;
         int w;
         ib = ($urandom_range(0, 3) == 0);
         pl = ($urandom_range(0, 4) != 0);
         w  = ib ? $urandom_range(1, 8) : $urandom_range(1, 12);
         run_period(w, ib, pl, "R3 random period");
         if (exp_lat) begin
            run_period(0, 0, 0, "R6 random hold");
            do_reset();
         end
      end
      run_period(0, 0, 0, "R3 flush");
      run_period(0, 0, 0, "R3 flush");
      if (exp_lat) do_reset();

      // R5 supply persistence
      tick();
      vsup_ovp = 1;
      repeat (OVPC - 1) tick();
      vsup_ovp = 0;
      tick(); tick();
      check("R5 one edge short", latched_off, 1'b0);
      vsup_ovp = 1;
      repeat (150) tick();
      vsup_ovp = 0; tick();
      vsup_ovp = 1;
      repeat (150) tick();
      check("R5 restart after drop", latched_off, 1'b0);
      vsup_ovp = 0; tick();
      vsup_ovp = 1;
      repeat (OVPC) tick();
      check("R5 not yet at count", latched_off, 1'b0);
      tick();
      check("R5 latched at count", latched_off, 1'b1);
      vsup_ovp = 0; gate_in = 1;
      repeat (20) tick();
      check("R6 hold after ovp clears", latched_off, 1'b1);
      check("R7 gate inhibited", gate_out, 1'b0);
      do_reset();
      gate_in = 1; #1;
      check("R7 gate passes after reset", gate_out, 1'b1);
      gate_in = 0;
      tick();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule